// File: doc/BRIEF.md
# PHY Bring-Up Script Sequencer

This block brings an attached Ethernet PHY up without software in the loop. A start pulse picks one of three scripts: configure, start up, or shut down. On every run the sequencer first pulses the management interface reset and waits for the controller to go idle. It then reads the two PHY identifier registers and builds a 32-bit device ID. The ID is matched against a small table of known devices, and the chosen device's script is run entry by entry from a compact command ROM until an end marker is reached.

Each script entry names a PHY register and carries an 18-bit data field. An ordinary value is written to the register. Two reserved values stand for a plain read and for a status poll. The poll entry reads the basic status register. When that register shows autonegotiation is supported but not yet complete, the sequencer re-reads it at a fixed tick interval until both the autonegotiation-complete bit and the link bit are set. It then waits a settle interval before moving on. If the re-read budget runs out, the run ends with an error.

The serial framing on the management bus is left to a separate controller. This block only issues register requests to that controller and watches its busy and not-valid flags. The result of a run is reported on done and error outputs, together with an error code and the index of the matched table entry.

Top module: `phy_seq_top`

## Requirements
- R1: `start_i` is accepted only while the sequencer is idle or finished, and the value of `list_sel_i` is latched at that moment. The list codes are 0 = config, 1 = startup, 2 = shutdown and 3 = an empty list. A start pulse that arrives while a run is in progress has no effect on that run.
- R2: Every accepted start drives `mgmt_reset_o` high for exactly one cycle. No transaction is issued until `mgmt_busy_i` has then been seen low; the controller raises busy in the cycle after the reset.
- R3: `mgmt_req_o` is a single-cycle pulse and is raised only while `mgmt_busy_i` is low. A write is complete once busy is low. A read is complete once busy and `mgmt_nvalid_i` are both low, and `mgmt_rdata_i` is taken in that cycle. The controller raises busy in the cycle after a request.
- R4: The two identifier reads come first in every run: register 2, then register 3. The device ID is {register 2 data, register 3 data}, with register 2 in bits 31:16.
- R5: The device table has three entries, each written as (stored value, shift): index 0 = (0, 28), index 1 = (32'h001410C6, 4), index 2 = (32'h00221612, 0). An entry matches when (ID >> shift) equals its stored value, and the highest matching index wins. If no entry matches, the run ends with error code 1 and no further transactions are issued.
- R6: A script entry is {register field [5:0], data field [17:0]}. A register field of 6'h3F is the end marker. A data field of 18'h10000 means read, 18'h20000 means status poll, and any other value is a write of its low 16 bits.
- R7: The scripts are as follows. Config: device 0 writes reg0=8000h, then reg0=1200h. Device 1 writes reg0=8000h, reg4=01E1h, reg0=1200h. Device 2 writes reg0=1200h. Startup, for every device: a read of reg1 whose data is discarded, a poll of reg1, then a read of reg (17 + device index). Shutdown: device 1 writes reg0=0800h; the other devices have an empty list.
- R8: On the first read of a poll entry, the sequencer starts polling only when bit 3 (autonegotiation able) is set and bit 5 (autonegotiation complete) is clear. Otherwise it moves straight to the next entry.
- R9: While polling, at least `TICK_CYCLES` cycles separate a poll request from the next re-read. Polling succeeds on a re-read that shows bit 5 and bit 2 (link) both set.
- R10: After a poll succeeds, at least `SETTLE_CYCLES` cycles pass before the next script request.
- R11: If `POLL_LIMIT` re-reads all fail, the run ends with error code 2. Error codes: 0 = none, 1 = no PHY, 2 = timeout.
- R12: Reaching the end marker raises `done_o` and sets `dev_idx_o` to the matched index. `done_o` and `error_o` are never high together. Both hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| list_sel_i | input | 2 | Script select (0 config, 1 startup, 2 shutdown, 3 empty) |
| mgmt_reset_o | output | 1 | Management interface reset pulse |
| mgmt_req_o | output | 1 | Transaction request pulse |
| mgmt_write_o | output | 1 | 1 = write, 0 = read |
| mgmt_reg_o | output | 5 | PHY register number |
| mgmt_wdata_o | output | 16 | Write data |
| mgmt_busy_i | input | 1 | Controller busy |
| mgmt_nvalid_i | input | 1 | Read data not yet valid |
| mgmt_rdata_i | input | 16 | Read data |
| done_o | output | 1 | Script finished normally |
| error_o | output | 1 | Run ended with an error |
| err_code_o | output | 2 | Error code |
| dev_idx_o | output | 2 | Matched device table index |

## Verification
The situation hardest to reach from the ports is the polling path: the tick wait, the re-read budget and the settle wait. The bench's controller model therefore serves the status register from a counter of status reads. That counter makes the complete and link bits appear on a chosen read number, or never. With it the bench can drive a run that passes straight through, a run that succeeds after several re-reads, a run that times out, and a device with no autonegotiation ability. Request timestamps taken from the model give the gaps that are checked against the tick and settle limits. A second start is injected during a polling wait to confirm that it is ignored.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int N_DEV      = 3;
    localparam int DEV_W      = 2;
    localparam int PHY_REG_W  = 5;
    localparam int PHY_DATA_W = 16;

    localparam logic [5:0]  END_REG   = 6'h3F;
    localparam logic [17:0] RD_CODE   = 18'h1_0000;
    localparam logic [17:0] POLL_CODE = 18'h2_0000;

    localparam int ST_LINK    = 2;
    localparam int ST_AN_ABLE = 3;
    localparam int ST_AN_DONE = 5;

    localparam logic [4:0] ID_HI_REG = 5'd2;
    localparam logic [4:0] ID_LO_REG = 5'd3;

    typedef struct packed {
        logic [5:0]  regf;
        logic [17:0] dataf;
    } cmd_t;

    typedef enum logic [1:0] {K_WRITE, K_READ, K_POLL, K_END} kind_e;
    typedef enum logic [1:0] {ERR_NONE = 2'd0, ERR_NOPHY = 2'd1, ERR_TIMEOUT = 2'd2} err_e;
    typedef enum logic [1:0] {L_CONFIG = 2'd0, L_STARTUP = 2'd1, L_SHUTDOWN = 2'd2, L_NONE = 2'd3} list_e;
    typedef enum logic [1:0] {PH_IDHI, PH_IDLO, PH_LIST} phase_e;
    typedef enum logic [2:0] {
        S_IDLE, S_RST_ON, S_RST_WAIT, S_ISSUE, S_XACT, S_POLL_WAIT, S_SETTLE, S_FIN
    } state_e;

    function automatic cmd_t wr_cmd(input logic [4:0] r, input logic [15:0] d);
        cmd_t c;
        c.regf  = {1'b0, r};
        c.dataf = {2'b00, d};
        return c;
    endfunction

    function automatic cmd_t rd_cmd(input logic [4:0] r);
        cmd_t c;
        c.regf  = {1'b0, r};
        c.dataf = RD_CODE;
        return c;
    endfunction

    function automatic cmd_t poll_cmd(input logic [4:0] r);
        cmd_t c;
        c.regf  = {1'b0, r};
        c.dataf = POLL_CODE;
        return c;
    endfunction

    function automatic cmd_t end_cmd();
        cmd_t c;
        c.regf  = END_REG;
        c.dataf = '0;
        return c;
    endfunction

    function automatic kind_e kind_of(input cmd_t c);
        if (c.regf == END_REG)         return K_END;
        else if (c.dataf == RD_CODE)   return K_READ;
        else if (c.dataf == POLL_CODE) return K_POLL;
        else                           return K_WRITE;
    endfunction

    function automatic logic [31:0] dev_stored(input int i);
        case (i)
            0:       return 32'h0000_0000;
            1:       return 32'h0014_10C6;
            2:       return 32'h0022_1612;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int dev_shift(input int i);
        case (i)
            0:       return 28;
            1:       return 4;
            default: return 0;
        endcase
    endfunction

    function automatic cmd_t script_at(input logic [DEV_W-1:0] dev, input list_e lst, input int idx);
        cmd_t c;
        c = end_cmd();
        case (lst)
            L_CONFIG: begin
                case (dev)
                    2'd0: begin
                        if (idx == 0)      c = wr_cmd(5'd0, 16'h8000);
                        else if (idx == 1) c = wr_cmd(5'd0, 16'h1200);
                    end
                    2'd1: begin
                        if (idx == 0)      c = wr_cmd(5'd0, 16'h8000);
                        else if (idx == 1) c = wr_cmd(5'd4, 16'h01E1);
                        else if (idx == 2) c = wr_cmd(5'd0, 16'h1200);
                    end
                    default: begin
                        if (idx == 0)      c = wr_cmd(5'd0, 16'h1200);
                    end
                endcase
            end
            L_STARTUP: begin
                if (idx == 0)      c = rd_cmd(5'd1);
                else if (idx == 1) c = poll_cmd(5'd1);
                else if (idx == 2) c = rd_cmd(5'd17 + {3'b000, dev});
            end
            L_SHUTDOWN: begin
                if (dev == 2'd1 && idx == 0) c = wr_cmd(5'd0, 16'h0800);
            end
            default: c = end_cmd();
        endcase
        return c;
    endfunction

endpackage

// File: rtl/phy_seq_id_match.sv
module phy_seq_id_match
    import phy_seq_pkg::*;
(
    input  logic [31:0]      id_i,
    output logic             hit_o,
    output logic [DEV_W-1:0] idx_o
);
    logic [N_DEV-1:0] match;

    for (genvar g = 0; g < N_DEV; g++) begin : g_entry
        assign match[g] = ((id_i >> dev_shift(g)) == dev_stored(g));
    end

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N_DEV; i++) begin
            if (match[i]) begin
                hit_o = 1'b1;
                idx_o = DEV_W'(i);
            end
        end
    end
endmodule

// File: rtl/phy_seq_rom.sv
module phy_seq_rom
    import phy_seq_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [DEV_W-1:0]     dev_i,
    input  list_e                list_i,
    input  logic [IDX_W-1:0]     idx_i,
    output kind_e                kind_o,
    output logic [PHY_REG_W-1:0] reg_o,
    output logic [15:0]          data_o
);
    cmd_t cmd;

    always_comb begin
        cmd    = script_at(dev_i, list_i, int'(idx_i));
        kind_o = kind_of(cmd);
        reg_o  = cmd.regf[PHY_REG_W-1:0];
        data_o = cmd.dataf[15:0];
    end
endmodule

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load_i)       cnt_q <= load_val_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/phy_seq_top.sv
module phy_seq_top
    import phy_seq_pkg::*;
#(
    parameter int TICK_CYCLES   = 50000,
    parameter int SETTLE_CYCLES = 25000000,
    parameter int POLL_LIMIT    = 5000,
    parameter int LIST_DEPTH    = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [1:0]  list_sel_i,
    output logic        mgmt_reset_o,
    output logic        mgmt_req_o,
    output logic        mgmt_write_o,
    output logic [4:0]  mgmt_reg_o,
    output logic [15:0] mgmt_wdata_o,
    input  logic        mgmt_busy_i,
    input  logic        mgmt_nvalid_i,
    input  logic [15:0] mgmt_rdata_i,
    output logic        done_o,
    output logic        error_o,
    output logic [1:0]  err_code_o,
    output logic [1:0]  dev_idx_o
);
    localparam int TMR_MAX = (SETTLE_CYCLES > TICK_CYCLES) ? SETTLE_CYCLES : TICK_CYCLES;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int PC_W    = $clog2(POLL_LIMIT + 1);
    localparam int IDX_W   = $clog2(LIST_DEPTH);
    localparam logic [TMR_W-1:0] TICK_LD   = TMR_W'(TICK_CYCLES);
    localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYCLES);
    localparam logic [PC_W-1:0]  PC_LAST   = PC_W'(POLL_LIMIT);

    state_e            st_q;
    phase_e            phase_q;
    list_e             list_q;
    logic [DEV_W-1:0]  dev_q;
    logic [IDX_W-1:0]  idx_q;
    logic [15:0]       id_hi_q;
    logic              in_poll_q;
    logic [PC_W-1:0]   poll_cnt_q;
    logic              done_q, err_q;
    err_e              code_q;

    kind_e             rom_kind, cur_kind;
    logic [4:0]        rom_reg, cur_reg;
    logic [15:0]       rom_data;
    logic              m_hit;
    logic [DEV_W-1:0]  m_idx;
    logic              t_load, t_exp;
    logic [TMR_W-1:0]  t_val;
    logic              xact_done;
    logic              st_able, st_andone, st_link;

    phy_seq_rom #(.IDX_W(IDX_W)) rom_i (
        .dev_i  (dev_q),
        .list_i (list_q),
        .idx_i  (idx_q),
        .kind_o (rom_kind),
        .reg_o  (rom_reg),
        .data_o (rom_data)
    );

    phy_seq_id_match match_i (
        .id_i  ({id_hi_q, mgmt_rdata_i}),
        .hit_o (m_hit),
        .idx_o (m_idx)
    );

    phy_seq_timer #(.W(TMR_W)) timer_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (t_load),
        .load_val_i (t_val),
        .expired_o  (t_exp)
    );

    // Current command: identifier reads come before the script itself
    always_comb begin
        case (phase_q)
            PH_IDHI: begin cur_kind = K_READ; cur_reg = ID_HI_REG; end
            PH_IDLO: begin cur_kind = K_READ; cur_reg = ID_LO_REG; end
            default: begin cur_kind = rom_kind; cur_reg = rom_reg; end
        endcase
    end

    assign st_able   = mgmt_rdata_i[ST_AN_ABLE];
    assign st_andone = mgmt_rdata_i[ST_AN_DONE];
    assign st_link   = mgmt_rdata_i[ST_LINK];

    assign xact_done = (st_q == S_XACT) && !mgmt_busy_i &&
                       ((cur_kind == K_WRITE) || !mgmt_nvalid_i);

    // Timer load decisions happen when a poll read completes
    always_comb begin
        t_load = 1'b0;
        t_val  = TICK_LD;
        if (xact_done && phase_q == PH_LIST && cur_kind == K_POLL) begin
            if (!in_poll_q) begin
                t_load = st_able && !st_andone;
            end else if (st_andone && st_link) begin
                t_load = 1'b1;
                t_val  = SETTLE_LD;
            end else begin
                t_load = (poll_cnt_q != PC_LAST);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            phase_q    <= PH_IDHI;
            list_q     <= L_CONFIG;
            dev_q      <= '0;
            idx_q      <= '0;
            id_hi_q    <= '0;
            in_poll_q  <= 1'b0;
            poll_cnt_q <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            code_q     <= ERR_NONE;
        end else begin
            case (st_q)
                S_IDLE, S_FIN: begin
                    if (start_i) begin
                        list_q <= list_e'(list_sel_i);
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                        code_q <= ERR_NONE;
                        st_q   <= S_RST_ON;
                    end
                end
                S_RST_ON: st_q <= S_RST_WAIT;
                S_RST_WAIT: begin
                    if (!mgmt_busy_i) begin
                        phase_q   <= PH_IDHI;
                        idx_q     <= '0;
                        in_poll_q <= 1'b0;
                        st_q      <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (cur_kind == K_END) begin
                        done_q <= 1'b1;
                        st_q   <= S_FIN;
                    end else if (!mgmt_busy_i) begin
                        st_q <= S_XACT;
                    end
                end
                S_XACT: begin
                    if (xact_done) begin
                        case (phase_q)
                            PH_IDHI: begin
                                id_hi_q <= mgmt_rdata_i;
                                phase_q <= PH_IDLO;
                                st_q    <= S_ISSUE;
                            end
                            PH_IDLO: begin
                                if (m_hit) begin
                                    dev_q   <= m_idx;
                                    phase_q <= PH_LIST;
                                    idx_q   <= '0;
                                    st_q    <= S_ISSUE;
                                end else begin
                                    err_q  <= 1'b1;
                                    code_q <= ERR_NOPHY;
                                    st_q   <= S_FIN;
                                end
                            end
                            default: begin
                                if (cur_kind != K_POLL) begin
                                    idx_q <= idx_q + 1'b1;
                                    st_q  <= S_ISSUE;
                                end else if (!in_poll_q) begin
                                    if (st_able && !st_andone) begin
                                        in_poll_q  <= 1'b1;
                                        poll_cnt_q <= '0;
                                        st_q       <= S_POLL_WAIT;
                                    end else begin
                                        idx_q <= idx_q + 1'b1;
                                        st_q  <= S_ISSUE;
                                    end
                                end else if (st_andone && st_link) begin
                                    in_poll_q <= 1'b0;
                                    st_q      <= S_SETTLE;
                                end else if (poll_cnt_q == PC_LAST) begin
                                    in_poll_q <= 1'b0;
                                    err_q     <= 1'b1;
                                    code_q    <= ERR_TIMEOUT;
                                    st_q      <= S_FIN;
                                end else begin
                                    st_q <= S_POLL_WAIT;
                                end
                            end
                        endcase
                    end
                end
                S_POLL_WAIT: begin
                    if (t_exp) begin
                        poll_cnt_q <= poll_cnt_q + 1'b1;
                        st_q       <= S_ISSUE;
                    end
                end
                S_SETTLE: begin
                    if (t_exp) begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= S_ISSUE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign mgmt_reset_o = (st_q == S_RST_ON);
    assign mgmt_req_o   = (st_q == S_ISSUE) && (cur_kind != K_END) && !mgmt_busy_i;
    assign mgmt_write_o = (cur_kind == K_WRITE);
    assign mgmt_reg_o   = cur_reg;
    assign mgmt_wdata_o = rom_data;
    assign done_o       = done_q;
    assign error_o      = err_q;
    assign err_code_o   = code_q;
    assign dev_idx_o    = dev_q;
endmodule

// File: rtl/phy_seq_chk.sv
module phy_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       mgmt_reset_o,
    input logic       mgmt_req_o,
    input logic       mgmt_busy_i,
    input logic       done_o,
    input logic       error_o,
    input logic [1:0] err_code_o
);
    a_r3_req_only_when_free: assert property (@(posedge clk) disable iff (rst)
        mgmt_req_o |-> !mgmt_busy_i);

    a_r3_req_single_cycle: assert property (@(posedge clk) disable iff (rst)
        mgmt_req_o |=> !mgmt_req_o);

    a_r2_reset_pulse: assert property (@(posedge clk) disable iff (rst)
        mgmt_reset_o |=> (!mgmt_reset_o && !mgmt_req_o));

    a_r2_no_req_in_reset: assert property (@(posedge clk) disable iff (rst)
        mgmt_reset_o |-> !mgmt_req_o);

    a_r12_done_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_o && error_o));

    a_r12_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

    a_r11_err_has_code: assert property (@(posedge clk) disable iff (rst)
        error_o |-> (err_code_o != 2'd0));
endmodule

bind phy_seq_top phy_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .mgmt_reset_o (mgmt_reset_o),
    .mgmt_req_o   (mgmt_req_o),
    .mgmt_busy_i  (mgmt_busy_i),
    .done_o       (done_o),
    .error_o      (error_o),
    .err_code_o   (err_code_o)
);

// File: tb/phy_seq_top_tb_top.sv
`timescale 1ns/1ps
module phy_seq_top_tb_top;
    localparam int TICK   = 20;
    localparam int SETTLE = 60;
    localparam int PLIM   = 4;
    localparam int LAT    = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  list_sel_i = 2'd0;
    logic        mgmt_reset_o, mgmt_req_o, mgmt_write_o;
    logic [4:0]  mgmt_reg_o;
    logic [15:0] mgmt_wdata_o;
    logic        busy = 1'b0, nv = 1'b0;
    logic [15:0] rdata = '0;
    logic        done_o, error_o;
    logic [1:0]  err_code_o, dev_idx_o;

    int n_cmp = 0, n_bad = 0;
    int cyc = 0, lat = 0;
    int n_tr = 0, rd1_cnt = 0, n_resets = 0, n_req_busy = 0;
    int t_wr[64], t_reg[64], t_dat[64], t_cyc[64];
    int e_n = 0;
    int e_wr[64], e_reg[64], e_dat[64];
    logic [31:0] id_v = '0;
    bit   able_v = 1'b0;
    int   comp_at_v = 1;

    always #10 clk = ~clk;

    phy_seq_top #(
        .TICK_CYCLES(TICK), .SETTLE_CYCLES(SETTLE), .POLL_LIMIT(PLIM), .LIST_DEPTH(8)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .list_sel_i(list_sel_i),
        .mgmt_reset_o(mgmt_reset_o), .mgmt_req_o(mgmt_req_o), .mgmt_write_o(mgmt_write_o),
        .mgmt_reg_o(mgmt_reg_o), .mgmt_wdata_o(mgmt_wdata_o),
        .mgmt_busy_i(busy), .mgmt_nvalid_i(nv), .mgmt_rdata_i(rdata),
        .done_o(done_o), .error_o(error_o), .err_code_o(err_code_o), .dev_idx_o(dev_idx_o)
    );

    // Management controller and PHY register model
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            busy <= 1'b0; nv <= 1'b0; lat <= 0;
        end else if (mgmt_reset_o) begin
            busy <= 1'b1; nv <= 1'b0; lat <= 4;
            n_resets = n_resets + 1;
        end else if (mgmt_req_o) begin
            if (busy) n_req_busy = n_req_busy + 1;
            if (n_tr < 64) begin
                t_wr[n_tr] = int'(mgmt_write_o); t_reg[n_tr] = int'(mgmt_reg_o);
                t_dat[n_tr] = int'(mgmt_wdata_o); t_cyc[n_tr] = cyc;
            end
            n_tr = n_tr + 1;
            busy <= 1'b1; nv <= !mgmt_write_o; lat <= LAT;
            if (!mgmt_write_o) begin
                if (mgmt_reg_o == 5'd2) rdata <= id_v[31:16];
                else if (mgmt_reg_o == 5'd3) rdata <= id_v[15:0];
                else if (mgmt_reg_o == 5'd1) begin
                    rdata <= (able_v ? 16'h0008 : 16'h0000) |
                             ((rd1_cnt + 1 >= comp_at_v) ? 16'h0024 : 16'h0000);
                    rd1_cnt = rd1_cnt + 1;
                end else rdata <= {11'd0, mgmt_reg_o};
            end
        end else if (lat > 0) begin
            lat <= lat - 1;
            if (lat == 1) begin busy <= 1'b0; nv <= 1'b0; end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic e_push(input int w, input int r, input int d);
        e_wr[e_n] = w; e_reg[e_n] = r; e_dat[e_n] = d; e_n = e_n + 1;
    endtask

    task automatic e_start();
        e_n = 0;
        e_push(0, 2, 0);
        e_push(0, 3, 0);
    endtask

    task automatic cmp_trace(input string rq);
        int bad;
        bad = -1;
        chk(n_tr == e_n, rq, "transaction count", n_tr, e_n);
        for (int i = 0; i < e_n && i < n_tr; i++) begin
            if (bad < 0 && (t_wr[i] != e_wr[i] || t_reg[i] != e_reg[i] ||
                            (e_wr[i] == 1 && t_dat[i] != e_dat[i])))
                bad = i;
        end
        if (bad < 0) chk(1'b1, rq, "transaction list", 0, 0);
        else chk(1'b0, rq, "transaction list entry",
                 (t_wr[bad] << 24) | (t_reg[bad] << 16) | t_dat[bad],
                 (e_wr[bad] << 24) | (e_reg[bad] << 16) | e_dat[bad]);
    endtask

    task automatic run_seq(input logic [1:0] lst, input logic [31:0] id, input bit ab,
                           input int cat, input int inject);
        @(negedge clk);
        id_v = id; able_v = ab; comp_at_v = cat;
        n_tr = 0; rd1_cnt = 0; n_resets = 0;
        list_sel_i = lst; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!done_o && !error_o, "R12", "status cleared by start", {done_o, error_o}, 0);
        for (int k = 0; k < 20000; k++) begin
            if (done_o || error_o) break;
            if (k == inject) begin
                list_sel_i = 2'd0; start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
            end else @(negedge clk);
        end
        chk(n_resets == 1, "R2", "reset pulses per run", n_resets, 1);
    endtask

    task automatic run_cfg(input logic [31:0] id, input int dev);
        run_seq(2'd0, id, 1'b0, 1, -1);
        e_start();
        if (dev == 0) begin e_push(1, 0, 16'h8000); e_push(1, 0, 16'h1200); end
        else if (dev == 1) begin
            e_push(1, 0, 16'h8000); e_push(1, 4, 16'h01E1); e_push(1, 0, 16'h1200);
        end else e_push(1, 0, 16'h1200);
        chk(done_o && !error_o, "R12", "config done", {done_o, error_o}, 2);
        chk(dev_idx_o == 2'(dev), "R5", "matched index", dev_idx_o, dev);
        cmp_trace("R7");
    endtask

    localparam logic [31:0] ID0 = 32'h0ABC_DEF0;
    localparam logic [31:0] ID1 = 32'h0141_0C65;
    localparam logic [31:0] ID2 = 32'h0022_1612;

    initial begin
        repeat (3) @(negedge clk);
        chk(!done_o && !error_o, "R12", "reset status", {done_o, error_o}, 0);
        chk(!mgmt_reset_o && !mgmt_req_o, "R2", "reset idle outputs", {mgmt_reset_o, mgmt_req_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!mgmt_req_o && !done_o, "R1", "no activity without start", {mgmt_req_o, done_o}, 0);

        // R4, R5, R7: config on every device, ID order and matching
        run_cfg(ID0, 0);
        chk(t_reg[0] == 2 && t_reg[1] == 3, "R4", "identifier read order", t_reg[0], 2);
        run_cfg(ID1, 1);
        run_cfg(ID2, 2);
        run_cfg(32'h0141_0C6F, 1);
        run_cfg(32'h0141_0C60, 1);
        run_cfg(32'h0022_1613, 0);

        // R5: no match
        run_seq(2'd0, 32'hF000_0001, 1'b0, 1, -1);
        chk(error_o && err_code_o == 2'd1, "R5", "no PHY error", err_code_o, 1);
        chk(n_tr == 2, "R5", "no transactions after failed match", n_tr, 2);

        // R8: already complete
        run_seq(2'd1, ID2, 1'b1, 1, -1);
        e_start(); e_push(0, 1, 0); e_push(0, 1, 0); e_push(0, 19, 0);
        chk(done_o, "R8", "startup complete at once", done_o, 1);
        cmp_trace("R8");
        chk(t_cyc[4] - t_cyc[3] < TICK, "R8", "no wait when complete", t_cyc[4] - t_cyc[3], 0);

        // R8: no autonegotiation ability
        run_seq(2'd1, ID0, 1'b0, 99, -1);
        e_start(); e_push(0, 1, 0); e_push(0, 1, 0); e_push(0, 17, 0);
        chk(done_o, "R8", "startup without ability", done_o, 1);
        cmp_trace("R8");

        // R9, R10: two re-reads then success
        run_seq(2'd1, ID1, 1'b1, 4, -1);
        e_start(); e_push(0, 1, 0); e_push(0, 1, 0); e_push(0, 1, 0); e_push(0, 1, 0);
        e_push(0, 18, 0);
        chk(done_o && !error_o, "R9", "poll success", {done_o, error_o}, 2);
        cmp_trace("R9");
        chk(t_cyc[4] - t_cyc[3] >= TICK && t_cyc[4] - t_cyc[3] <= TICK + 10, "R9",
            "tick gap 1", t_cyc[4] - t_cyc[3], TICK);
        chk(t_cyc[5] - t_cyc[4] >= TICK && t_cyc[5] - t_cyc[4] <= TICK + 10, "R9",
            "tick gap 2", t_cyc[5] - t_cyc[4], TICK);
        chk(t_cyc[6] - t_cyc[5] >= SETTLE && t_cyc[6] - t_cyc[5] <= SETTLE + 10, "R10",
            "settle gap", t_cyc[6] - t_cyc[5], SETTLE);

        // R11: never completes
        run_seq(2'd1, ID1, 1'b1, 99, -1);
        chk(error_o && err_code_o == 2'd2, "R11", "timeout code", err_code_o, 2);
        chk(rd1_cnt == 2 + PLIM, "R11", "status reads before timeout", rd1_cnt, 2 + PLIM);

        // R1: start during a run is ignored
        run_seq(2'd1, ID0, 1'b1, 3, 30);
        e_start(); e_push(0, 1, 0); e_push(0, 1, 0); e_push(0, 1, 0); e_push(0, 17, 0);
        chk(done_o, "R1", "run survives extra start", done_o, 1);
        cmp_trace("R1");

        // R6, R7: shutdown lists and empty list
        run_seq(2'd2, ID1, 1'b0, 1, -1);
        e_start(); e_push(1, 0, 16'h0800);
        cmp_trace("R7");
        run_seq(2'd2, ID0, 1'b0, 1, -1);
        e_start();
        chk(done_o, "R6", "empty shutdown done", done_o, 1);
        cmp_trace("R6");
        run_seq(2'd3, ID2, 1'b0, 1, -1);
        e_start();
        chk(done_o && dev_idx_o == 2'd2, "R1", "empty list select", dev_idx_o, 2);
        cmp_trace("R1");

        // R12: status holds
        repeat (10) @(negedge clk);
        chk(done_o && !error_o, "R12", "done held", {done_o, error_o}, 2);
        chk(n_req_busy == 0, "R3", "requests while busy", n_req_busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp = n_cmp + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule